// File: doc/BRIEF.md
# Two-Comparator Data Watchpoint Unit

This debug block observes every data access presented on a 32-bit load/store port and raises a single-cycle hit pulse when the access satisfies a programmed watch condition. Two independent address comparators, called E and F, each test the access address against their own programmed value. Each comparator has a compare type (equal, unsigned greater-than or unsigned less-than) and a read/write qualifier. A combine stage then selects E alone, F alone or the AND of both. With E set to greater-than (start minus one) and F set to less-than (end plus one), the pair covers any word-aligned address range. A range that starts at address 0 uses F alone. A range that ends at the top of the address space uses E alone, so neither programmed value wraps.

Software programs four registers over a simple write port: the E value, the F value, a first control word (compare types and qualifiers) and a second control word (combine select and three enable bits that must all be set). The expected sequence is to clear the second control word, rewrite the other three, and write the second control word last. While it is zero, no hit can occur. On a hit, the access address is latched into a capture register that is visible on an output port.

Top module: `watchpoint_unit`

## Requirements
- R1: After reset all four registers are zero, `hit` is 0 and `hit_addr` is 0, and no access produces a hit until software programs the unit.
- R2: Compare type 3'b110 in control word 1 (bits [31:29] for E, bits [28:26] for F) makes the comparator match only when the access address is strictly greater than its value, using an unsigned comparison.
- R3: Compare type 3'b101 makes the comparator match only when the access address is strictly less than its value, using an unsigned comparison.
- R4: Compare type 3'b100 makes the comparator match only when the access address equals its value.
- R5: The qualifier field in control word 1 (bits [19:18] for E, bits [17:16] for F) selects which accesses can match: 2'b00 matches reads and writes, 2'b01 matches reads only, 2'b11 matches writes only, and 2'b10 matches nothing.
- R6: Control word 2 bits [27:26] select the combine mode: 2'b00 uses E alone, 2'b01 uses F alone, 2'b10 requires both E and F, and 2'b11 never hits.
- R7: A hit requires control word 2 bits 31, 25 and 1 all set. If any of these bits is clear, including when the whole word is zero, no hit occurs.
- R8: `hit` is high for exactly the one cycle after a clock edge at which `acc_valid` was high with a qualifying access. It never rises without `acc_valid`.
- R9: On a hit, `hit_addr` shows the address of the access that caused it. `hit_addr` holds its value across accesses that do not hit.
- R10: Compare type codes other than 3'b100, 3'b110 and 3'b101 disable their comparator, so it never matches.
- R11: Ranges are detected over the full 32-bit unsigned space, including a range at the top of the space (E alone), a range starting at 0 (F alone), ranges of 65535 bytes or more, and addresses above 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 E value, 1 F value, 2 control word 1, 3 control word 2 |
| reg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | 32 | Data access address |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| hit | output | 1 | Watchpoint hit pulse |
| hit_addr | output | 32 | Captured address of the last hit |

## Verification
A register write is applied at the rising edge where `reg_we` is sampled, so an access in the following cycle already uses the new value. A qualifying access strobe sampled at one rising edge produces `hit` and the updated `hit_addr` right after that same edge, and `hit` drops again after the next edge. The bench drives inputs and reads outputs only at falling edges. It reads the result of an access at the falling edge right after the strobe's rising edge, and checks that the pulse has ended one falling edge later.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int REG_W = 32;

  // compare type codes
  typedef enum logic [2:0] {
    CMP_EQ = 3'b100,
    CMP_GT = 3'b110,
    CMP_LT = 3'b101
  } cmp_type_e;

  // access direction qualifier codes
  typedef enum logic [1:0] {
    QUAL_ANY   = 2'b00,
    QUAL_READ  = 2'b01,
    QUAL_RSVD  = 2'b10,
    QUAL_WRITE = 2'b11
  } rw_qual_e;

  // combine select codes
  typedef enum logic [1:0] {
    COMB_E    = 2'b00,
    COMB_F    = 2'b01,
    COMB_BOTH = 2'b10,
    COMB_NONE = 2'b11
  } comb_sel_e;

  // register select codes
  localparam logic [1:0] SEL_VAL_E = 2'd0;
  localparam logic [1:0] SEL_VAL_F = 2'd1;
  localparam logic [1:0] SEL_CTL1  = 2'd2;
  localparam logic [1:0] SEL_CTL2  = 2'd3;

  // control word 1 field positions (low bit of each field)
  localparam int CTL1_TYPE_E_LSB = 29;
  localparam int CTL1_TYPE_F_LSB = 26;
  localparam int CTL1_QUAL_E_LSB = 18;
  localparam int CTL1_QUAL_F_LSB = 16;

  // control word 2 field positions
  localparam int CTL2_EN_MAIN = 31;
  localparam int CTL2_EN_MODE = 25;
  localparam int CTL2_EN_AUX  = 1;
  localparam int CTL2_SEL_LSB = 26;

endpackage

// File: rtl/wp_regfile.sv
module wp_regfile
  import wp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] val_e,
  output logic [REG_W-1:0] val_f,
  output logic [REG_W-1:0] ctl1,
  output logic [REG_W-1:0] ctl2
);

  localparam int NREG = 4;

  logic [REG_W-1:0] reg_q [NREG];
  logic [NREG-1:0]  reg_en;

  // per-register clock enables
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      reg_en[i] = we && (sel == i[1:0]);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= '0;
      end else if (reg_en[g]) begin
        reg_q[g] <= wdata;
      end
    end
  end

  assign val_e = reg_q[SEL_VAL_E];
  assign val_f = reg_q[SEL_VAL_F];
  assign ctl1  = reg_q[SEL_CTL1];
  assign ctl2  = reg_q[SEL_CTL2];

endmodule

// File: rtl/wp_comparator.sv
module wp_comparator
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] value,
  input  logic [2:0]        ctype,
  input  logic [1:0]        qual,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output logic              match
);

  logic addr_ok;
  logic dir_ok;

  // unsigned address test; unknown codes never match
  always_comb begin
    case (ctype)
      CMP_EQ:  addr_ok = (addr == value);
      CMP_GT:  addr_ok = (addr >  value);
      CMP_LT:  addr_ok = (addr <  value);
      default: addr_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (qual)
      QUAL_ANY:   dir_ok = 1'b1;
      QUAL_READ:  dir_ok = !is_write;
      QUAL_WRITE: dir_ok = is_write;
      default:    dir_ok = 1'b0;
    endcase
  end

  assign match = addr_ok && dir_ok;

endmodule

// File: rtl/wp_hit_stage.sv
module wp_hit_stage
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_e,
  input  logic              match_f,
  input  logic [1:0]        comb_sel,
  input  logic              armed,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_addr
);

  logic              combined;
  logic              hit_d;
  logic              hit_q;
  logic              cap_en;
  logic [ADDR_W-1:0] cap_d;
  logic [ADDR_W-1:0] cap_q;

  always_comb begin
    case (comb_sel)
      COMB_E:    combined = match_e;
      COMB_F:    combined = match_f;
      COMB_BOTH: combined = match_e && match_f;
      default:   combined = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    hit_d  = acc_valid && armed && combined;
    cap_en = hit_d;
    cap_d  = acc_addr;
  end

  // pulse register, updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  // capture register, loaded only on a hit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= cap_d;
    end
  end

  assign hit      = hit_q;
  assign hit_addr = cap_q;

endmodule

// File: rtl/watchpoint_unit.sv
module watchpoint_unit
  import wp_pkg::*;
#(
  // access address width; must not exceed the 32-bit register width
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_addr
);

  localparam int NCMP = 2;

  logic [REG_W-1:0]  val_e_q;
  logic [REG_W-1:0]  val_f_q;
  logic [REG_W-1:0]  ctl1_q;
  logic [REG_W-1:0]  ctl2_q;

  logic [ADDR_W-1:0] cmp_val   [NCMP];
  logic [2:0]        cmp_type  [NCMP];
  logic [1:0]        cmp_qual  [NCMP];
  logic [NCMP-1:0]   cmp_match;
  logic              armed;

  wp_regfile u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .val_e (val_e_q),
    .val_f (val_f_q),
    .ctl1  (ctl1_q),
    .ctl2  (ctl2_q)
  );

  // field extraction: index 0 is comparator E, index 1 is comparator F
  assign cmp_val[0]  = val_e_q[ADDR_W-1:0];
  assign cmp_val[1]  = val_f_q[ADDR_W-1:0];
  assign cmp_type[0] = ctl1_q[CTL1_TYPE_E_LSB +: 3];
  assign cmp_type[1] = ctl1_q[CTL1_TYPE_F_LSB +: 3];
  assign cmp_qual[0] = ctl1_q[CTL1_QUAL_E_LSB +: 2];
  assign cmp_qual[1] = ctl1_q[CTL1_QUAL_F_LSB +: 2];

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    wp_comparator #(.ADDR_W(ADDR_W)) u_cmp (
      .value    (cmp_val[g]),
      .ctype    (cmp_type[g]),
      .qual     (cmp_qual[g]),
      .addr     (acc_addr),
      .is_write (acc_write),
      .match    (cmp_match[g])
    );
  end

  assign armed = ctl2_q[CTL2_EN_MAIN] && ctl2_q[CTL2_EN_MODE] && ctl2_q[CTL2_EN_AUX];

  wp_hit_stage #(.ADDR_W(ADDR_W)) u_hit (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_e   (cmp_match[0]),
    .match_f   (cmp_match[1]),
    .comb_sel  (ctl2_q[CTL2_SEL_LSB +: 2]),
    .armed     (armed),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .hit       (hit),
    .hit_addr  (hit_addr)
  );

endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic              hit,
  input logic [ADDR_W-1:0] hit_addr,
  input logic [31:0]       val_e_q,
  input logic [31:0]       val_f_q,
  input logic [31:0]       ctl1_q,
  input logic [31:0]       ctl2_q
);

  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(acc_valid)); // R8

  AST_CTL2_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl2_q == 32'h0) |=> !hit); // R7

  AST_CAPTURE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_addr == $past(acc_addr))); // R9

  AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> $stable(hit_addr)); // R9

  AST_RANGE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ctl2_q == 32'h8A00_0002 && ctl1_q == 32'hD400_0000)
      |=> (hit == ($past(acc_addr) > $past(val_e_q[ADDR_W-1:0]) &&
                   $past(acc_addr) < $past(val_f_q[ADDR_W-1:0])))); // R6

  AST_READ_ONLY_E: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && ctl1_q[19:18] == 2'b01 && ctl2_q[27:26] == 2'b00)
      |=> !hit); // R5

endmodule

bind watchpoint_unit wp_checker #(.ADDR_W(ADDR_W)) u_wp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .acc_write (acc_write),
  .hit       (hit),
  .hit_addr  (hit_addr),
  .val_e_q   (val_e_q),
  .val_f_q   (val_f_q),
  .ctl1_q    (ctl1_q),
  .ctl2_q    (ctl2_q)
);

// File: tb/watchpoint_unit_tb.sv
module watchpoint_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        acc_write;
  logic        hit;
  logic [31:0] hit_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  watchpoint_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_write (acc_write),
    .hit       (hit),
    .hit_addr  (hit_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // encodings taken from the requirements
  localparam logic [2:0] TEQ = 3'b100, TGT = 3'b110, TLT = 3'b101, TRSV = 3'b111;
  localparam logic [31:0] C1_RANGE = {TGT, TLT, 6'b0, 2'b00, 2'b00, 16'b0};
  localparam logic [31:0] C1_EQ    = {TEQ, TLT, 6'b0, 2'b00, 2'b00, 16'b0};
  localparam logic [31:0] C1_EQRD  = {TEQ, TLT, 6'b0, 2'b01, 2'b00, 16'b0};
  localparam logic [31:0] C1_EQWR  = {TEQ, TLT, 6'b0, 2'b11, 2'b00, 16'b0};
  localparam logic [31:0] C1_EQQ10 = {TEQ, TLT, 6'b0, 2'b10, 2'b00, 16'b0};
  localparam logic [31:0] C1_RSV   = {TRSV, TLT, 6'b0, 2'b00, 2'b00, 16'b0};
  localparam logic [31:0] C1_T000  = {3'b000, TLT, 6'b0, 2'b00, 2'b00, 16'b0};
  localparam logic [31:0] C2_E     = 32'h8200_0002;
  localparam logic [31:0] C2_F     = 32'h8600_0002;
  localparam logic [31:0] C2_EF    = 32'h8A00_0002;
  localparam logic [31:0] C2_SEL11 = 32'h8E00_0002;
  localparam logic [31:0] C2_NO1   = 32'h8A00_0000;
  localparam logic [31:0] C2_NO25  = 32'h8800_0002;
  localparam logic [31:0] C2_NO31  = 32'h0A00_0002;

  // {req, val_e, val_f, ctl1, ctl2, addr, write, expected hit}
  localparam int VW = 8 + 32 * 5 + 2;
  localparam int NV = 30;
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'd2,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_EF,    32'h0000_1000, 1'b0, 1'b1}, // R2 first byte
    {8'd2,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_EF,    32'h0000_0FFF, 1'b0, 1'b0}, // R2 equal to E value
    {8'd3,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_EF,    32'h0000_1FFF, 1'b0, 1'b1}, // R3 last byte
    {8'd3,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_EF,    32'h0000_2000, 1'b0, 1'b0}, // R3 equal to F value
    {8'd5,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_EF,    32'h0000_1800, 1'b1, 1'b1}, // R5 store, any qualifier
    {8'd4,  32'h0000_4000, 32'h0000_0000, C1_EQ,    C2_E,     32'h0000_4000, 1'b0, 1'b1}, // R4 equal
    {8'd4,  32'h0000_4000, 32'h0000_0000, C1_EQ,    C2_E,     32'h0000_4004, 1'b0, 1'b0}, // R4 next word
    {8'd5,  32'h0000_4000, 32'h0000_0000, C1_EQRD,  C2_E,     32'h0000_4000, 1'b1, 1'b0}, // R5 read-only, store
    {8'd5,  32'h0000_4000, 32'h0000_0000, C1_EQRD,  C2_E,     32'h0000_4000, 1'b0, 1'b1}, // R5 read-only, load
    {8'd5,  32'h0000_4000, 32'h0000_0000, C1_EQWR,  C2_E,     32'h0000_4000, 1'b1, 1'b1}, // R5 write-only, store
    {8'd5,  32'h0000_4000, 32'h0000_0000, C1_EQWR,  C2_E,     32'h0000_4000, 1'b0, 1'b0}, // R5 write-only, load
    {8'd5,  32'h0000_4000, 32'h0000_0000, C1_EQQ10, C2_E,     32'h0000_4000, 1'b0, 1'b0}, // R5 code 10
    {8'd10, 32'h0000_4000, 32'h0000_0000, C1_RSV,   C2_E,     32'h0000_4000, 1'b0, 1'b0}, // R10 code 111
    {8'd10, 32'h0000_4000, 32'h0000_0000, C1_RSV,   C2_E,     32'h0000_5000, 1'b0, 1'b0}, // R10 code 111
    {8'd10, 32'h0000_4000, 32'h0000_0000, C1_T000,  C2_E,     32'h0000_4000, 1'b0, 1'b0}, // R10 code 000
    {8'd6,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_E,     32'h0000_3000, 1'b0, 1'b1}, // R6 E alone ignores F
    {8'd6,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_F,     32'h0000_0800, 1'b0, 1'b1}, // R6 F alone ignores E
    {8'd6,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_EF,    32'h0000_3000, 1'b0, 1'b0}, // R6 both needed
    {8'd6,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_SEL11, 32'h0000_1000, 1'b0, 1'b0}, // R6 code 11
    {8'd7,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_NO1,   32'h0000_1000, 1'b0, 1'b0}, // R7 bit 1 clear
    {8'd7,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_NO25,  32'h0000_1000, 1'b0, 1'b0}, // R7 bit 25 clear
    {8'd7,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_NO31,  32'h0000_1000, 1'b0, 1'b0}, // R7 bit 31 clear
    {8'd7,  32'h0000_0FFF, 32'h0000_2000, C1_RANGE, 32'h0,    32'h0000_1000, 1'b0, 1'b0}, // R7 all clear
    {8'd11, 32'hFFFF_FFFB, 32'h0000_0000, C1_RANGE, C2_E,     32'hFFFF_FFFC, 1'b0, 1'b1}, // R11 top range
    {8'd11, 32'hFFFF_FFFB, 32'h0000_0000, C1_RANGE, C2_E,     32'hFFFF_FFFB, 1'b1, 1'b0}, // R11 below top range
    {8'd11, 32'h0000_0000, 32'h0000_0010, C1_RANGE, C2_F,     32'h0000_0000, 1'b0, 1'b1}, // R11 range at zero
    {8'd11, 32'h0000_0000, 32'h0000_0010, C1_RANGE, C2_F,     32'h0000_0010, 1'b0, 1'b0}, // R11 past zero range
    {8'd11, 32'h0000_FFFF, 32'h0002_0000, C1_RANGE, C2_EF,    32'h0001_FFFC, 1'b1, 1'b1}, // R11 64 KiB range
    {8'd11, 32'h7FFF_FFFF, 32'h9000_0000, C1_RANGE, C2_EF,    32'h8000_0000, 1'b0, 1'b1}, // R11 unsigned
    {8'd11, 32'h7FFF_FFFF, 32'h9000_0000, C1_RANGE, C2_EF,    32'h0000_0004, 1'b0, 1'b0}  // R11 unsigned low
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // all driving starts and ends at a falling edge
  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic program_unit(input logic [31:0] ve, input logic [31:0] vf,
                              input logic [31:0] c1, input logic [31:0] c2);
    wr(2'd3, 32'h0);
    wr(2'd0, ve);
    wr(2'd1, vf);
    wr(2'd2, c1);
    wr(2'd3, c2);
  endtask

  // result is due right after the edge that samples the strobe
  task automatic access(input logic [31:0] a, input logic w, input logic v);
    acc_valid = v; acc_addr = a; acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] last;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0; acc_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and no hit while unprogrammed
    check(1, {31'b0, hit}, 32'h0, "hit after reset");
    check(1, hit_addr, 32'h0, "hit_addr after reset");
    access(32'h0000_0000, 1'b0, 1'b1);
    check(1, {31'b0, hit}, 32'h0, "hit unprogrammed addr 0");
    access(32'hFFFF_FFFF, 1'b1, 1'b1);
    check(1, {31'b0, hit}, 32'h0, "hit unprogrammed top");

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      program_unit(v[161:130], v[129:98], v[97:66], v[65:34]);
      access(v[33:2], v[1], 1'b1);
      check(int'(v[169:162]), {31'b0, hit}, {31'b0, v[0]}, $sformatf("vector %0d hit", i));
      if (v[0]) check(9, hit_addr, v[33:2], $sformatf("vector %0d capture", i));
    end

    // R8 pulse lasts one cycle
    program_unit(32'h0000_0FFF, 32'h0000_2000, C1_RANGE, C2_EF);
    access(32'h0000_1234, 1'b0, 1'b1);
    check(8, {31'b0, hit}, 32'h1, "hit after strobe");
    @(negedge clk);
    check(8, {31'b0, hit}, 32'h0, "hit one cycle later");
    // R8 matching address without strobe
    access(32'h0000_1100, 1'b0, 1'b0);
    check(8, {31'b0, hit}, 32'h0, "no strobe no hit");

    // R9 capture holds over misses
    last = 32'h0000_1234;
    access(32'h0000_5000, 1'b0, 1'b1);
    check(9, {31'b0, hit}, 32'h0, "miss access");
    check(9, hit_addr, last, "capture held after miss");
    access(32'h0000_1100, 1'b0, 1'b0);
    check(9, hit_addr, last, "capture held without strobe");

    // R7 clearing control word 2 silences an armed range
    wr(2'd3, 32'h0);
    access(32'h0000_1200, 1'b0, 1'b1);
    check(7, {31'b0, hit}, 32'h0, "ctl2 cleared");
    // R7 rewriting comparators while disarmed stays quiet
    wr(2'd0, 32'h0000_5FFF);
    access(32'h0000_6000, 1'b0, 1'b1);
    check(7, {31'b0, hit}, 32'h0, "partial update");
    wr(2'd3, C2_E);
    access(32'h0000_6000, 1'b0, 1'b1);
    check(7, {31'b0, hit}, 32'h1, "rearmed");
    check(9, hit_addr, 32'h0000_6000, "capture after rearm");

    // R1 reset mid-run returns to zero
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, hit_addr, 32'h0, "hit_addr after second reset");
    access(32'h0000_6000, 1'b0, 1'b1);
    check(1, {31'b0, hit}, 32'h0, "disarmed after second reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule